// File: doc/BRIEF.md
# Hardware Binary Semaphore Array

This block keeps a fixed set of binary semaphores in dedicated flip-flops rather than in protected memory. Software can claim and hand back a shared resource by driving one command strobe, with no trip through the operating system. Each slot is always in one of three states: unused, free to take, or held. A slot leaves the unused state only when it is allocated, and it returns there only when it is freed while not held.

Four one-hot strobes select the command: allocate, free, acquire and release. A 32-bit identifier input names the slot for acquire, release and free. Allocate ignores that input. It picks the lowest-numbered unused slot and returns that slot's number. Every command is taken in at one clock edge, and its result (an error flag plus a 32-bit value) is registered at that same edge. On success the value is a slot number. On failure it is a small reason code, and no slot changes state. Between commands the outputs keep showing the last result.

Top module: `hw_sem_array`

## Requirements
- R1: While reset is high at a clock edge, every slot becomes unused and both `err_out` and `result_out` become 0.
- R2: Allocate (`cmd_create` alone) ignores `id_in`. When a slot is unused, it picks the lowest-numbered unused slot, makes it free to take, and returns its number with `err_out`=0.
- R3: Allocate with no unused slot fails with code 1.
- R4: Acquire (`cmd_pend` alone) on a slot that is free to take makes it held, and returns the slot number with `err_out`=0.
- R5: Release (`cmd_post` alone) on a held slot makes it free to take, and returns the slot number with `err_out`=0.
- R6: Free (`cmd_destroy` alone) on a slot that is free to take makes it unused, and returns the slot number with `err_out`=0. The only state moves a slot can make are unused→free to take, free to take→held, held→free to take and free to take→unused.
- R7: Acquire, release or free with `id_in` at or above COUNT fails with code 2.
- R8: Acquire, release or free on an unused slot fails with code 3.
- R9: Acquire on a held slot fails with code 4. Release on a slot that is free to take fails with code 5. Free on a held slot fails with code 6.
- R10: Two or more strobes high together fail with code 7, whatever `id_in` is.
- R11: A failed command changes no slot. With no strobe high, `err_out` and `result_out` keep their values.
- R12: A command's result is on the outputs from the clock edge that samples the command until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_create | input | 1 | Allocate strobe |
| cmd_destroy | input | 1 | Free strobe |
| cmd_pend | input | 1 | Acquire strobe |
| cmd_post | input | 1 | Release strobe |
| id_in | input | 32 | Slot identifier |
| result_out | output | 32 | Slot number on success, reason code on failure |
| err_out | output | 1 | High when the last command failed |

## Verification
Every result is due exactly one rising edge after the command is set up. The bench drives strobes and the identifier on the falling edge and then waits through one rising edge. It compares both outputs on the following falling edge, well away from the register update. Idle cycles are checked on the same schedule, so held outputs are compared one edge after a cycle with no strobe. The bench never reads slot state directly. Each earlier failure is judged by what the next commands on that slot return.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        SEM_UNUSED = 2'd0,
        SEM_AVAIL  = 2'd1,
        SEM_HELD   = 2'd2
    } sem_state_e;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_CREATE  = 3'd1,
        OP_DESTROY = 3'd2,
        OP_PEND    = 3'd3,
        OP_POST    = 3'd4,
        OP_CLASH   = 3'd5
    } sem_op_e;

    typedef enum logic [3:0] {
        FAULT_NONE     = 4'd0,
        FAULT_FULL     = 4'd1,
        FAULT_BAD_ID   = 4'd2,
        FAULT_UNUSED   = 4'd3,
        FAULT_HELD     = 4'd4,
        FAULT_NOT_HELD = 4'd5,
        FAULT_BUSY     = 4'd6,
        FAULT_CLASH    = 4'd7
    } sem_fault_e;

    // strobes packed as {create, destroy, pend, post}
    function automatic sem_op_e decode_op(input logic [3:0] strobes);
        sem_op_e op;
        case (strobes)
            4'b0000: op = OP_NONE;
            4'b1000: op = OP_CREATE;
            4'b0100: op = OP_DESTROY;
            4'b0010: op = OP_PEND;
            4'b0001: op = OP_POST;
            default: op = OP_CLASH;
        endcase
        return op;
    endfunction

    function automatic sem_fault_e target_fault(input sem_op_e op, input sem_state_e st);
        sem_fault_e f;
        f = FAULT_NONE;
        if (st == SEM_UNUSED) begin
            f = FAULT_UNUSED;
        end else begin
            case (op)
                OP_PEND:    if (st == SEM_HELD)  f = FAULT_HELD;
                OP_POST:    if (st == SEM_AVAIL) f = FAULT_NOT_HELD;
                OP_DESTROY: if (st == SEM_HELD)  f = FAULT_BUSY;
                default:    f = FAULT_NONE;
            endcase
        end
        return f;
    endfunction

    function automatic sem_state_e step_to(input sem_op_e op);
        sem_state_e s;
        case (op)
            OP_PEND: s = SEM_HELD;
            OP_DESTROY: s = SEM_UNUSED;
            default: s = SEM_AVAIL;
        endcase
        return s;
    endfunction

    function automatic logic legal_move(input sem_state_e from_s, input sem_state_e to_s);
        return (from_s == SEM_UNUSED && to_s == SEM_AVAIL) ||
               (from_s == SEM_AVAIL  && to_s == SEM_HELD)  ||
               (from_s == SEM_HELD   && to_s == SEM_AVAIL) ||
               (from_s == SEM_AVAIL  && to_s == SEM_UNUSED);
    endfunction

endpackage

// File: rtl/sem_slot.sv
module sem_slot
    import sem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  sem_state_e next_state,
    output sem_state_e state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEM_UNUSED;
        end else if (wr_en) begin
            state <= next_state;
        end
    end

    AST_LEGAL_MOVE: assert property (@(posedge clk) disable iff (rst)
        (state != $past(state)) |-> legal_move($past(state), state)); // R6

    AST_NO_SPARE_CODE: assert property (@(posedge clk) disable iff (rst)
        state != 2'd3); // R6

endmodule

// File: rtl/sem_lowest_free.sv
module sem_lowest_free #(
    parameter int COUNT = 8,
    localparam int IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1
) (
    input  logic [COUNT-1:0] free_vec,
    output logic             found,
    output logic [IDX_W-1:0] index
);

    always_comb begin
        found = 1'b0;
        index = '0;
        for (int i = COUNT - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                found = 1'b1;
                index = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/hw_sem_array.sv
module hw_sem_array
    import sem_pkg::*;
#(
    parameter int COUNT  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_create,
    input  logic              cmd_destroy,
    input  logic              cmd_pend,
    input  logic              cmd_post,
    input  logic [DATA_W-1:0] id_in,
    output logic [DATA_W-1:0] result_out,
    output logic              err_out
);

    localparam int IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1;

    logic [3:0]         strobes;
    sem_op_e            op;
    logic               id_ok;
    logic [IDX_W-1:0]   idx;
    sem_state_e         states [COUNT];
    sem_state_e         tgt_state;
    logic [COUNT-1:0]   free_vec;
    logic [2*COUNT-1:0] state_bits;
    logic               any_free;
    logic [IDX_W-1:0]   free_idx;
    sem_fault_e         fault;
    logic               commit;
    sem_state_e         next_state;

    assign strobes    = {cmd_create, cmd_destroy, cmd_pend, cmd_post};
    assign op         = decode_op(strobes);
    assign id_ok      = (id_in < DATA_W'(COUNT));
    assign idx        = id_in[IDX_W-1:0];
    assign tgt_state  = id_ok ? states[idx] : SEM_UNUSED;
    assign next_state = step_to(op);

    sem_lowest_free #(.COUNT(COUNT)) u_pick (
        .free_vec (free_vec),
        .found    (any_free),
        .index    (free_idx)
    );

    always_comb begin
        fault = FAULT_NONE;
        case (op)
            OP_CLASH:  fault = FAULT_CLASH;
            OP_CREATE: if (!any_free) fault = FAULT_FULL;
            OP_PEND, OP_POST, OP_DESTROY: begin
                if (!id_ok) fault = FAULT_BAD_ID;
                else        fault = target_fault(op, tgt_state);
            end
            default:   fault = FAULT_NONE;
        endcase
    end

    assign commit = (op != OP_NONE) && (op != OP_CLASH) && (fault == FAULT_NONE);

    for (genvar i = 0; i < COUNT; i++) begin : g_slot
        logic hit;
        assign hit = (op == OP_CREATE) ? (free_idx == IDX_W'(i))
                                       : (id_ok && idx == IDX_W'(i));
        sem_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (commit && hit),
            .next_state (next_state),
            .state      (states[i])
        );
        assign free_vec[i]           = (states[i] == SEM_UNUSED);
        assign state_bits[2*i +: 2]  = states[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_out    <= 1'b0;
            result_out <= '0;
        end else if (op != OP_NONE) begin
            err_out <= (fault != FAULT_NONE);
            if (fault != FAULT_NONE)  result_out <= DATA_W'(fault);
            else if (op == OP_CREATE) result_out <= DATA_W'(free_idx);
            else                      result_out <= id_in;
        end
    end

    AST_FAIL_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        ($past(strobes) != 4'b0000 && err_out) |-> (state_bits == $past(state_bits))); // R11

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(strobes) == 4'b0000) |-> ($stable(err_out) && $stable(result_out))); // R11

    AST_CLASH_CODE: assert property (@(posedge clk) disable iff (rst)
        ($countones($past(strobes)) > 1) |-> (err_out && result_out == DATA_W'(7))); // R10

    AST_CREATE_RANGE: assert property (@(posedge clk) disable iff (rst)
        ($past(strobes) == 4'b1000 && !err_out) |-> (result_out < DATA_W'(COUNT))); // R2

    AST_BAD_ID: assert property (@(posedge clk) disable iff (rst)
        ($onehot0($past(strobes)) && $past(strobes) != 4'b0000 && $past(strobes) != 4'b1000
         && $past(id_in) >= DATA_W'(COUNT)) |-> (err_out && result_out == DATA_W'(2))); // R7

endmodule

// File: tb/hw_sem_array_test.sv
`timescale 1ns/1ps
module hw_sem_array_test;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        c_cr = 1'b0, c_de = 1'b0, c_pe = 1'b0, c_po = 1'b0;
    logic [31:0] id = '0;
    logic [31:0] result_out;
    logic        err_out;

    int checks = 0;
    int errors = 0;
    int model [N];          // 0 unused, 1 free to take, 2 held
    logic        last_err = 1'b0;
    logic [31:0] last_res = '0;

    always #2.5 clk = ~clk;

    hw_sem_array #(.COUNT(N), .DATA_W(32)) uut (
        .clk(clk), .rst(rst),
        .cmd_create(c_cr), .cmd_destroy(c_de), .cmd_pend(c_pe), .cmd_post(c_po),
        .id_in(id), .result_out(result_out), .err_out(err_out)
    );

    task automatic check(input string tag, input logic e_err, input logic [31:0] e_res);
        checks++;
        if (err_out !== e_err || result_out !== e_res) begin
            errors++;
            $display("FAIL %s (R12 timing): err=%0b result=%0d expected err=%0b result=%0d",
                     tag, err_out, result_out, e_err, e_res);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        {c_cr, c_de, c_pe, c_po} = 4'b0000;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N; i++) model[i] = 0;
        last_err = 1'b0;
        last_res = '0;
        check("R1 reset", 1'b0, 32'd0);
    endtask

    // strobes = {create, destroy, pend, post}; called on a falling edge
    task automatic issue(input logic [3:0] s, input logic [31:0] ident);
        logic        e_err;
        logic [31:0] e_res;
        string       tag;
        int          lo;
        e_err = 1'b0;
        e_res = ident;
        if (s == 4'b0000) begin
            tag = "R11 idle hold"; e_err = last_err; e_res = last_res;
        end else if ($countones(s) > 1) begin
            tag = "R10 clash"; e_err = 1'b1; e_res = 7;
        end else if (s == 4'b1000) begin
            lo = -1;
            for (int i = N - 1; i >= 0; i--) if (model[i] == 0) lo = i;
            if (lo < 0) begin tag = "R3 full"; e_err = 1'b1; e_res = 1; end
            else begin tag = "R2 create"; e_res = 32'(lo); model[lo] = 1; end
        end else if (ident >= N) begin
            tag = "R7 bad id"; e_err = 1'b1; e_res = 2;
        end else if (model[ident] == 0) begin
            tag = "R8 unused"; e_err = 1'b1; e_res = 3;
        end else if (s == 4'b0010) begin
            if (model[ident] == 2) begin tag = "R9 pend held"; e_err = 1'b1; e_res = 4; end
            else begin tag = "R4 pend"; model[ident] = 2; end
        end else if (s == 4'b0001) begin
            if (model[ident] == 1) begin tag = "R9 post free"; e_err = 1'b1; e_res = 5; end
            else begin tag = "R5 post"; model[ident] = 1; end
        end else begin
            if (model[ident] == 2) begin tag = "R9 destroy held"; e_err = 1'b1; e_res = 6; end
            else begin tag = "R6 destroy"; model[ident] = 0; end
        end
        {c_cr, c_de, c_pe, c_po} = s;
        id = ident;
        @(posedge clk);
        @(negedge clk);
        {c_cr, c_de, c_pe, c_po} = 4'b0000;
        check(tag, e_err, e_res);
        last_err = e_err;
        last_res = e_res;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        for (int i = 0; i < N; i++) issue(4'b0010, 32'(i));           // R8 after reset (R1)
        for (int i = 0; i <= N; i++) issue(4'b1000, 32'hDEAD_0000 + 32'(i)); // R2, R3
        issue(4'b0000, 32'd9);                                         // R11
        for (int pass = 0; pass < 3; pass++)
            for (int i = 0; i < N + 2; i++)
                for (int o = 0; o < 3; o++) begin
                    issue(4'b0100 >> o, 32'(i));
                    if (o == 1) issue(4'b0000, 32'(i));
                end
        issue(4'b0010, 32'hFFFF_FFFF);                                 // R7 top id
        for (int s = 0; s < 16; s++) issue(4'(s), 32'd1);              // R10 every combo
        for (int i = 0; i < N; i++) issue(4'b1000, 32'(N - i));        // refill low first
        issue(4'b0010, 32'd2);
        issue(4'b1100, 32'd2);                                         // clash, no effect
        issue(4'b0001, 32'd2);
        issue(4'b0100, 32'd2);
        issue(4'b0100, 32'd0);
        issue(4'b1000, 32'd3);                                         // picks 0 again
        issue(4'b0010, 32'd3);
        do_reset();                                                    // R1 mid-run
        for (int i = 0; i < N; i++) issue(4'b0001, 32'(i));
        issue(4'b1000, 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule